// File: doc/BRIEF.md
# Fine Interpolation Pulse Generator

This block drives one axis of a stepping or pulse-train servo drive. An external processor does the coarse interpolation. Once per interpolation period it hands over a signed count of how far the axis must move. The block spreads that count over the period as evenly spaced pulses of a fixed width, so the drive never receives a burst. A multi-axis controller places one instance per axis, typically four.

Two output formats can be chosen while running. In step/direction format one line carries the pulses and the other carries a direction level. In forward/reverse format each direction has its own pulse line. The next increment is double-buffered: it can be written at any time during the current period, and it is picked up at the period boundary. A ready flag asks for the next value. An increment that cannot fit at the configured pulse width is clipped to the largest count that does fit, and a sticky flag reports the event.

Top module: `fine_interp_pulse`

## Requirements
- R1: In each period the active pulse line carries exactly min(|inc|, L) pulses, where L = floor(floor(P/2)/W), P is the period length in clocks (values below 2 count as 2) and W is the pulse width (0 counts as 1).
- R2: With m pulses in a period, pulse j (j = 1..m) rises ceil((j*P - floor(P/2))/m) clocks after the first clock of the period, so consecutive gaps differ by at most one clock.
- R3: Every pulse stays high for exactly W clocks, ends inside its own period, and every pulse line is low in the first clock of a period.
- R4: With fmt_sel = 0 (step/direction), pulse_a carries the pulses and pulse_b is the direction level: 1 for a negative increment and 0 otherwise. The level is valid from the first clock of the period and holds for the whole period.
- R5: With fmt_sel = 1 (forward/reverse), a positive increment pulses pulse_a, a negative increment pulses pulse_b, and the other line stays low for the whole period.
- R6: inc_in is captured on any clock with inc_valid high and takes effect at the next period boundary. A later write before the boundary replaces an earlier one. req_next is low while a value is waiting and high again from the first clock of the next period.
- R7: A period that starts with no waiting value produces no pulses and a low direction level.
- R8: overrun goes high from the first clock of a period whose increment magnitude exceeds L, and it stays high until reset.
- R9: Reset drives both pulse lines low, req_next high and overrun low. The first clock after reset is a period boundary, and an increment presented on that clock is used at once. Period length, pulse width and fmt_sel are sampled only at period boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_len | input | PERIOD_W | Interpolation period length in clocks |
| pulse_width | input | WIDTH_W | Pulse high time in clocks |
| fmt_sel | input | 1 | Output format: 0 step/direction, 1 forward/reverse |
| inc_in | input | INC_W | Signed pulse count for one period |
| inc_valid | input | 1 | Write strobe for inc_in |
| pulse_a | output | 1 | Step pulses (format 0) or forward pulses (format 1) |
| pulse_b | output | 1 | Direction level (format 0) or reverse pulses (format 1) |
| req_next | output | 1 | High while no increment is waiting |
| overrun | output | 1 | Sticky flag for a clipped increment |

## Verification
Any error in the accumulator shows up within one period: the pulse count comes out wrong, or a rise lands away from its computed slot. A stale or misloaded buffer entry shows up at the next boundary as the wrong count, the wrong direction level or the wrong active line. A width counter or period counter that is off by one makes a pulse run past the period edge, or makes a period one clock long or short. Either way the rise positions of every later period shift, so the fault is visible by the second period.

// File: rtl/fip_pkg.sv
package fip_pkg;

  // Output line format, sampled at each period boundary.
  typedef enum logic {
    FMT_STEP_DIR = 1'b0,
    FMT_FWD_REV  = 1'b1
  } fmt_e;

endpackage

// File: rtl/fip_period_timer.sv
// Counts clocks inside the interpolation period, flags the boundary and
// latches the period length and pulse width for the coming period.
module fip_period_timer #(
  parameter int PERIOD_W = 16,
  parameter int WIDTH_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_len,
  input  logic [WIDTH_W-1:0]  pulse_width,
  output logic                period_end,
  output logic                period_first,
  output logic [PERIOD_W-1:0] new_period,
  output logic [PERIOD_W-1:0] act_period,
  output logic [WIDTH_W-1:0]  new_width,
  output logic [WIDTH_W-1:0]  act_width
);

  localparam int CW = PERIOD_W + 1;

  // A period shorter than two clocks cannot hold a pulse and its gap.
  function automatic logic [PERIOD_W-1:0] clamp_period(input logic [PERIOD_W-1:0] p);
    return (p < PERIOD_W'(2)) ? PERIOD_W'(2) : p;
  endfunction

  function automatic logic [WIDTH_W-1:0] clamp_width(input logic [WIDTH_W-1:0] w);
    return (w == '0) ? WIDTH_W'(1) : w;
  endfunction

  logic [PERIOD_W-1:0] cnt_q;

  assign new_period = clamp_period(period_len);
  assign new_width  = clamp_width(pulse_width);

  // act_period is zero only straight after reset, which makes the first
  // clock a boundary.
  assign period_end = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, act_period};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      act_period   <= '0;
      act_width    <= WIDTH_W'(1);
      period_first <= 1'b0;
    end else begin
      period_first <= period_end;
      if (period_end) begin
        cnt_q      <= '0;
        act_period <= new_period;
        act_width  <= new_width;
      end else begin
        cnt_q <= cnt_q + PERIOD_W'(1);
      end
    end
  end

endmodule

// File: rtl/fip_incr_buffer.sv
// Holds the waiting increment and loads the active magnitude, sign and
// format at each boundary, clipping the magnitude to what fits.
module fip_incr_buffer #(
  parameter int INC_W    = 16,
  parameter int PERIOD_W = 16,
  parameter int WIDTH_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    period_end,
  input  logic signed [INC_W-1:0] inc_in,
  input  logic                    inc_valid,
  input  logic                    fmt_sel,
  input  logic [PERIOD_W-1:0]     new_period,
  input  logic [WIDTH_W-1:0]      new_width,
  output logic [PERIOD_W-1:0]     mag_q,
  output logic                    neg_q,
  output fip_pkg::fmt_e           fmt_q,
  output logic                    req_next,
  output logic                    overrun
);

  localparam int CMPW = (INC_W > PERIOD_W) ? INC_W : PERIOD_W;

  function automatic logic [INC_W-1:0] magnitude(input logic signed [INC_W-1:0] v);
    logic [INC_W-1:0] u;
    u = v;
    return v[INC_W-1] ? (~u + INC_W'(1)) : u;
  endfunction

  // Largest count whose pulses and gaps of equal width fit in the period.
  function automatic logic [PERIOD_W-1:0] pulse_limit(input logic [PERIOD_W-1:0] p,
                                                      input logic [WIDTH_W-1:0]  w);
    return (p >> 1) / PERIOD_W'(w);
  endfunction

  logic signed [INC_W-1:0] shad_q;
  logic                    shad_full_q;
  logic signed [INC_W-1:0] pick_inc;
  logic [INC_W-1:0]        pick_mag;
  logic [PERIOD_W-1:0]     lim;
  logic [PERIOD_W-1:0]     eff;
  logic                    sat;

  always_comb begin
    if (shad_full_q)    pick_inc = shad_q;
    else if (inc_valid) pick_inc = inc_in;
    else                pick_inc = '0;
    pick_mag = magnitude(pick_inc);
    lim      = pulse_limit(new_period, new_width);
    sat      = CMPW'(pick_mag) > CMPW'(lim);
    eff      = sat ? lim : PERIOD_W'(pick_mag);
  end

  assign req_next = !shad_full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shad_q      <= '0;
      shad_full_q <= 1'b0;
      mag_q       <= '0;
      neg_q       <= 1'b0;
      fmt_q       <= fip_pkg::FMT_STEP_DIR;
      overrun     <= 1'b0;
    end else begin
      if (period_end) begin
        mag_q <= eff;
        neg_q <= pick_inc[INC_W-1];
        fmt_q <= fip_pkg::fmt_e'(fmt_sel);
        if (sat) overrun <= 1'b1;
        // A value written on the boundary while another waits stays queued.
        if (shad_full_q && inc_valid) begin
          shad_q      <= inc_in;
          shad_full_q <= 1'b1;
        end else begin
          shad_full_q <= 1'b0;
        end
      end else if (inc_valid) begin
        shad_q      <= inc_in;
        shad_full_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fip_dda.sv
// Rate accumulator: adds the magnitude each clock and requests a pulse
// each time the sum crosses the period length.
module fip_dda #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                period_end,
  input  logic [PERIOD_W-1:0] new_period,
  input  logic [PERIOD_W-1:0] act_period,
  input  logic [PERIOD_W-1:0] mag,
  output logic                fire,
  output logic [PERIOD_W-1:0] acc_q
);

  localparam int CW = PERIOD_W + 1;

  function automatic logic [PERIOD_W-1:0] start_phase(input logic [PERIOD_W-1:0] p);
    return p >> 1;
  endfunction

  logic [CW-1:0] sum;

  assign sum  = CW'(acc_q) + CW'(mag);
  // The half-period start phase keeps the boundary clock free of crossings.
  assign fire = !period_end && (sum >= CW'(act_period));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (period_end) begin
      acc_q <= start_phase(new_period);
    end else if (fire) begin
      acc_q <= PERIOD_W'(sum - CW'(act_period));
    end else begin
      acc_q <= PERIOD_W'(sum);
    end
  end

endmodule

// File: rtl/fip_pulse_shaper.sv
// Stretches each request to the configured width and maps it onto the
// two output lines according to the active format.
module fip_pulse_shaper #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [WIDTH_W-1:0] act_width,
  input  logic               neg,
  input  fip_pkg::fmt_e      fmt,
  output logic               pulse_a,
  output logic               pulse_b,
  output logic               pulse_on
);

  logic [WIDTH_W-1:0] left_q;

  assign pulse_on = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (fire) begin
      left_q <= act_width;
    end else if (pulse_on) begin
      left_q <= left_q - WIDTH_W'(1);
    end
  end

  always_comb begin
    case (fmt)
      fip_pkg::FMT_FWD_REV: begin
        pulse_a = pulse_on & !neg;
        pulse_b = pulse_on & neg;
      end
      default: begin
        pulse_a = pulse_on;
        pulse_b = neg;
      end
    endcase
  end

endmodule

// File: rtl/fine_interp_pulse.sv
// One-axis fine interpolator: spreads a signed count evenly over a period.
module fine_interp_pulse #(
  parameter int PERIOD_W = 16,
  parameter int INC_W    = 16,
  parameter int WIDTH_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PERIOD_W-1:0]     period_len,
  input  logic [WIDTH_W-1:0]      pulse_width,
  input  logic                    fmt_sel,
  input  logic signed [INC_W-1:0] inc_in,
  input  logic                    inc_valid,
  output logic                    pulse_a,
  output logic                    pulse_b,
  output logic                    req_next,
  output logic                    overrun
);

  // Internal events, named so the checker can reach them.
  logic                period_end;
  logic                period_first;
  logic [PERIOD_W-1:0] new_period;
  logic [PERIOD_W-1:0] act_period;
  logic [WIDTH_W-1:0]  new_width;
  logic [WIDTH_W-1:0]  act_width;
  logic [PERIOD_W-1:0] mag_q;
  logic                neg_q;
  fip_pkg::fmt_e       fmt_q;
  logic                fire;
  logic [PERIOD_W-1:0] acc_q;
  logic                pulse_on;

  fip_period_timer #(.PERIOD_W(PERIOD_W), .WIDTH_W(WIDTH_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .period_len(period_len), .pulse_width(pulse_width),
    .period_end(period_end), .period_first(period_first),
    .new_period(new_period), .act_period(act_period),
    .new_width(new_width), .act_width(act_width)
  );

  fip_incr_buffer #(.INC_W(INC_W), .PERIOD_W(PERIOD_W), .WIDTH_W(WIDTH_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .period_end(period_end),
    .inc_in(inc_in), .inc_valid(inc_valid), .fmt_sel(fmt_sel),
    .new_period(new_period), .new_width(new_width),
    .mag_q(mag_q), .neg_q(neg_q), .fmt_q(fmt_q),
    .req_next(req_next), .overrun(overrun)
  );

  fip_dda #(.PERIOD_W(PERIOD_W)) u_dda (
    .clk(clk), .rst_n(rst_n), .period_end(period_end),
    .new_period(new_period), .act_period(act_period), .mag(mag_q),
    .fire(fire), .acc_q(acc_q)
  );

  fip_pulse_shaper #(.WIDTH_W(WIDTH_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .fire(fire), .act_width(act_width),
    .neg(neg_q), .fmt(fmt_q),
    .pulse_a(pulse_a), .pulse_b(pulse_b), .pulse_on(pulse_on)
  );

endmodule

// File: rtl/fip_checker.sv
// Temporal properties of the pulse generator, bound onto the top module.
module fip_checker #(
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                period_end,
  input logic                period_first,
  input logic                inc_valid,
  input logic                fire,
  input logic                pulse_on,
  input logic                neg_q,
  input logic [PERIOD_W-1:0] acc_q,
  input logic [PERIOD_W-1:0] act_period,
  input fip_pkg::fmt_e       fmt_q,
  input logic                pulse_a,
  input logic                pulse_b,
  input logic                req_next,
  input logic                overrun
);

  // R1: the remainder never reaches the period once a period is running.
  p_acc_below_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_period != '0) |-> (acc_q < act_period));

  // R2: a new pulse never starts while the previous one is still high.
  p_fire_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !pulse_on);

  // R3: no pulse spills into the next period.
  p_clear_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_first |-> !pulse_on);

  // R4: the direction level changes only on a period's first clock.
  p_dir_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_first |-> $stable(neg_q));

  // R5: in forward/reverse format the two lines are never high together.
  p_lines_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == fip_pkg::FMT_FWD_REV) |-> !(pulse_a && pulse_b));

  // R6: a boundary without a concurrent write leaves nothing waiting.
  p_ready_after_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !inc_valid) |=> req_next);

  // R8: the overrun flag is sticky.
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind fine_interp_pulse fip_checker #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_end(period_end),
  .period_first(period_first), .inc_valid(inc_valid), .fire(fire),
  .pulse_on(pulse_on), .neg_q(neg_q), .acc_q(acc_q),
  .act_period(act_period), .fmt_q(fmt_q), .pulse_a(pulse_a),
  .pulse_b(pulse_b), .req_next(req_next), .overrun(overrun)
);

// File: tb/fine_interp_pulse_tb_top.sv
module fine_interp_pulse_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int IW = 16;
  localparam int WW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [PW-1:0]        period_len = '0;
  logic [WW-1:0]        pulse_width = '0;
  logic                 fmt_sel = 1'b0;
  logic signed [IW-1:0] inc_in = '0;
  logic                 inc_valid = 1'b0;
  logic                 pulse_a;
  logic                 pulse_b;
  logic                 req_next;
  logic                 overrun;

  int errors = 0;
  int checks = 0;
  int cur_p;
  int cur_w;
  bit cur_fmt;
  bit ov_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  fine_interp_pulse #(.PERIOD_W(PW), .INC_W(IW), .WIDTH_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .period_len(period_len),
    .pulse_width(pulse_width), .fmt_sel(fmt_sel), .inc_in(inc_in),
    .inc_valid(inc_valid), .pulse_a(pulse_a), .pulse_b(pulse_b),
    .req_next(req_next), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reset with a new configuration; the increment presented on the
  // release clock is consumed by the first boundary (R9).
  task automatic start_cfg(input int p, input int w, input bit f, input int first);
    rst_n       = 1'b0;
    inc_valid   = 1'b0;
    inc_in      = '0;
    period_len  = PW'(p);
    pulse_width = WW'(w);
    fmt_sel     = f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pulse_a && !pulse_b, "R9 reset pulse lines", int'({pulse_a, pulse_b}), 0);
    chk(req_next == 1'b1, "R9 reset ready", int'(req_next), 1);
    chk(overrun == 1'b0, "R9 reset overrun", int'(overrun), 0);
    rst_n     = 1'b1;
    inc_in    = IW'(first);
    inc_valid = 1'b1;
    cur_p     = p;
    cur_w     = w;
    cur_fmt   = f;
    ov_exp    = 1'b0;
  endtask

  // Observe one whole period that plays inc_cur; optionally queue the next.
  task automatic run_period(input int inc_cur, input bit wr, input int inc_nxt,
                            input bit dup, input bit fmt_nxt);
    int lim, mag, m_eff, nrise, run, p_half, maxg, ming, gap, bad_a, bad_e, expr;
    bit neg, prev, line, other, ok_dir, ok_other, ok_width, ok_pos;
    int rise[64];
    p_half = cur_p / 2;
    lim    = p_half / cur_w;
    mag    = (inc_cur < 0) ? -inc_cur : inc_cur;
    m_eff  = (mag > lim) ? lim : mag;
    neg    = (inc_cur < 0);
    if (mag > lim) ov_exp = 1'b1;
    nrise = 0; run = 0; prev = 1'b0; other = 1'b0;
    ok_dir = 1'b1; ok_other = 1'b1; ok_width = 1'b1; ok_pos = 1'b1;
    bad_a = 0; bad_e = 0;
    for (int s = 0; s < cur_p; s++) begin
      @(negedge clk);
      if (!cur_fmt) begin
        line = pulse_a;
        if (pulse_b != neg) ok_dir = 1'b0;
      end else begin
        line  = neg ? pulse_b : pulse_a;
        other = neg ? pulse_a : pulse_b;
        if (other) ok_other = 1'b0;
      end
      if (s == 0) begin
        chk(!line, "R3 line low on first clock", int'(line), 0);
        chk(req_next == 1'b1, "R6 ready after boundary", int'(req_next), 1);
        chk(overrun == ov_exp, "R8 overrun flag", int'(overrun), int'(ov_exp));
      end
      if (s == 2) chk(req_next == !wr, "R6 ready low while value waits", int'(req_next), int'(!wr));
      if (s == cur_p - 1) chk(req_next == !wr, "R6 value held to boundary", int'(req_next), int'(!wr));
      if (line && !prev) begin
        if (nrise < 64) rise[nrise] = s;
        nrise++;
      end
      if (line) run++;
      else if (prev) begin
        if (run != cur_w) ok_width = 1'b0;
        run = 0;
      end
      prev = line;
      // Drive after sampling.
      if (s == 0) inc_valid = 1'b0;
      if (s == 1 && wr) begin
        inc_in    = dup ? IW'(777) : IW'(inc_nxt);
        inc_valid = 1'b1;
        fmt_sel   = fmt_nxt;
      end
      if (s == 2) begin
        if (wr && dup) begin
          inc_in    = IW'(inc_nxt);
          inc_valid = 1'b1;
        end else begin
          inc_valid = 1'b0;
        end
      end
      if (s == 3) inc_valid = 1'b0;
    end
    if (run > 0 && run != cur_w) ok_width = 1'b0;

    chk(nrise == m_eff, "R1 pulses per period", nrise, m_eff);
    if (inc_cur == 0) chk(nrise == 0, "R7 idle period has no pulses", nrise, 0);
    for (int k = 0; k < nrise && k < m_eff && k < 64; k++) begin
      expr = ((k + 1) * cur_p - p_half + m_eff - 1) / m_eff;
      if (ok_pos && rise[k] != expr) begin
        ok_pos = 1'b0; bad_a = rise[k]; bad_e = expr;
      end
    end
    chk(ok_pos, "R2 rise position", bad_a, bad_e);
    if (nrise >= 2 && nrise <= 64) begin
      maxg = 0; ming = cur_p;
      for (int k = 0; k + 1 < nrise; k++) begin
        gap = rise[k + 1] - rise[k];
        if (gap > maxg) maxg = gap;
        if (gap < ming) ming = gap;
      end
      chk(maxg - ming <= 1, "R2 gap spread", maxg - ming, 1);
    end
    chk(ok_width, "R3 pulse width", int'(ok_width), 1);
    if (!cur_fmt) chk(ok_dir, "R4 direction level held", int'(ok_dir), 1);
    else          chk(ok_other, "R5 unused line low", int'(ok_other), 1);
    if (wr) cur_fmt = fmt_nxt;
  endtask

  task automatic sweep(input int p, input int w, input bit f, input int lo, input int hi);
    start_cfg(p, w, f, lo);
    for (int v = lo; v <= hi; v++) run_period(v, v < hi, v + 1, (v % 3) == 0, f);
    run_period(0, 1'b0, 0, 1'b0, f);   // R7: nothing queued
  endtask

  initial begin
    sweep(20, 2, 1'b0, -7, 7);
    sweep(17, 1, 1'b1, -9, 9);
    sweep(24, 3, 1'b0, -5, 5);
    sweep(9, 1, 1'b1, -5, 5);
    sweep(8, 4, 1'b0, -2, 2);
    // Format switches at boundaries, latest write wins (R4, R5, R6).
    start_cfg(20, 2, 1'b0, 3);
    run_period(3, 1'b1, -4, 1'b0, 1'b1);
    run_period(-4, 1'b1, 2, 1'b1, 1'b0);
    run_period(2, 1'b1, -3, 1'b1, 1'b1);
    run_period(-3, 1'b0, 0, 1'b0, 1'b1);
    run_period(0, 1'b0, 0, 1'b0, 1'b1);
    // Extreme magnitudes clip and set the sticky flag (R8).
    start_cfg(20, 2, 1'b1, -32768);
    run_period(-32768, 1'b1, 32767, 1'b0, 1'b0);
    run_period(32767, 1'b1, 1, 1'b0, 1'b0);
    run_period(1, 1'b0, 0, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule